// File: doc/BRIEF.md
# Latched Framer Event Status Register

This block holds the sticky status word that a T1/E1 receive framer's performance monitor shows to a host. Eight event pulses, each one clock wide, come in from the framer. Each pulse sets its own bit in a 16-bit status word, and the bit stays set until the host reads the word. The read strobe clears every bit except one whose event arrives in the same cycle as the read. Such a bit stays set, so that event is never lost.

Three configuration inputs control which bits exist:

- The framing family input selects DS1 or CEPT.
- The CRC mode input marks ESF (in DS1) or CRC-4 (in CEPT) framing.
- The transmit-alignment enable input applies in CEPT only.

A bit that is not valid in the current configuration neither sets nor reads as 1. In DS1 the transmit-alignment bit is forced to read as 1.

The read data port is combinational. During the cycle of the strobe it shows the word as it was before the clear.

Top module: `pmStatusReg`

## Requirements
- R1: After reset every stored bit is 0. In DS1 the word reads 0x0040 (the forced bit 6 only). In CEPT it reads 0x0000.
- R2: Event inputs map to read bits as follows:
  - eventIn[0] line format violation sets bit 13.
  - eventIn[1] frame-bit error sets bit 12.
  - eventIn[2] CRC error sets bit 10.
  - eventIn[3] excessive CRC sets bit 9.
  - eventIn[4] E-bit zero sets bit 8.
  - eventIn[5] continuous E-bits sets bit 7.
  - eventIn[6] transmit alignment loss sets bit 6.
  - eventIn[7] new frame alignment sets bit 5.
- R3: A set bit holds its value in every cycle without a read strobe.
- R4: A cycle with rdStrobe high clears every bit from the next cycle on. During the strobe cycle, rdData shows the value held before the clear.
- R5: An event that is high in the same cycle as rdStrobe leaves its bit at 1 after the read.
- R6: Bits 15, 14, 11 and 4 down to 0 always read 0.
- R7: With modeCept=0 (DS1), bit 6 always reads 1, whatever the events or reads.
- R8: With crcMode=0, eventIn[2] and eventIn[3] are ignored, and bits 10 and 9 read 0.
- R9: Unless modeCept=1 and crcMode=1, eventIn[4] and eventIn[5] are ignored, and bits 8 and 7 read 0.
- R10: With modeCept=1 and txAlignEn=0, eventIn[6] is ignored and bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCept | input | 1 | 0 selects DS1 framing, 1 selects CEPT |
| crcMode | input | 1 | 1 selects ESF (DS1) or CRC-4 (CEPT) |
| txAlignEn | input | 1 | CEPT only: 1 lets the transmit alignment loss event set its bit |
| eventIn | input | 8 | One-cycle event pulses, index mapping given in R2 |
| rdStrobe | input | 1 | Host read strobe; clears the word after this cycle |
| rdData | output | 16 | Status word as seen by the host |

## Verification
The bench sweeps all eight configurations. In each one it fires every event alone, reads once with the same event coincident and once without, and reads a final time to confirm the clear.

The corner cases it targets, and what a faulty design would do:

- Event coincident with a read: a design that gives the clear priority drops that event.
- Read data during the strobe: a design that shows the post-clear value hides events from the host.
- Masked events: a design that gates only the read view, and not the capture, shows stale 1s after a mode change.
- Forced DS1 bit: a design that stores this bit, instead of forcing it, shows 0 after a read.

// File: rtl/pmStatusPkg.sv
package pmStatusPkg;
  localparam int NUM_EVT = 8;
  localparam int REG_W   = 16;

  typedef enum logic [2:0] {
    EV_LFV   = 3'd0,
    EV_FBE   = 3'd1,
    EV_CRC   = 3'd2,
    EV_XCRC  = 3'd3,
    EV_EBIT  = 3'd4,
    EV_CEBIT = 3'd5,
    EV_TXAL  = 3'd6,
    EV_NFA   = 3'd7
  } evt_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_EVT-1:0] setMask;
    logic [NUM_EVT-1:0] clrMask;
    logic [NUM_EVT-1:0] viewMask;
    logic [NUM_EVT-1:0] forceMask;
  } ctrlStrobe_t;

  // position of each event's bit in the host word (decoded by host software)
  function automatic int bitPos(input int idx);
    case (idx)
      0:       return 13;
      1:       return 12;
      2:       return 10;
      3:       return 9;
      4:       return 8;
      5:       return 7;
      6:       return 6;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/pmStatusCtrl.sv
module pmStatusCtrl
  import pmStatusPkg::*;
(
  input  logic               modeCept,
  input  logic               crcMode,
  input  logic               txAlignEn,
  input  logic [NUM_EVT-1:0] eventIn,
  input  logic               rdStrobe,
  output ctrlStrobe_t        strb
);
  logic [NUM_EVT-1:0] validMask;
  logic [NUM_EVT-1:0] forcedMask;

  always_comb begin
    validMask           = '1;
    validMask[EV_CRC]   = crcMode;
    validMask[EV_XCRC]  = crcMode;
    validMask[EV_EBIT]  = modeCept & crcMode;
    validMask[EV_CEBIT] = modeCept & crcMode;
    validMask[EV_TXAL]  = modeCept & txAlignEn;
    forcedMask          = '0;
    forcedMask[EV_TXAL] = ~modeCept;
  end

  always_comb begin
    strb.setMask   = eventIn & validMask;
    strb.clrMask   = {NUM_EVT{rdStrobe}};
    strb.viewMask  = validMask;
    strb.forceMask = forcedMask;
  end
endmodule

// File: rtl/pmStatusData.sv
module pmStatusData
  import pmStatusPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  output logic [REG_W-1:0] rdData
);
  logic [NUM_EVT-1:0] stat;

  always_ff @(posedge clk) begin
    if (!rstN) stat <= '0;
    else       stat <= (stat & ~strb.clrMask) | strb.setMask;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_EVT; i++)
      rdData[bitPos(i)] = (stat[i] & strb.viewMask[i]) | strb.forceMask[i];
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : gChk
    a_r2_set: assert property (@(posedge clk) disable iff (!rstN)
      strb.setMask[g] |=> stat[g]);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (stat[g] && !strb.clrMask[g]) |=> stat[g]);
    a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrMask[g] && !strb.setMask[g]) |=> !stat[g]);
    a_r5_keep: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrMask[g] && strb.setMask[g]) |=> stat[g]);
  end

  always_comb begin
    a_r6_reserved: assert (rdData[15:14] == 2'b00 && rdData[11] == 1'b0 && rdData[4:0] == 5'd0);
  end
endmodule

// File: rtl/pmStatusReg.sv
module pmStatusReg
  import pmStatusPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeCept,
  input  logic               crcMode,
  input  logic               txAlignEn,
  input  logic [NUM_EVT-1:0] eventIn,
  input  logic               rdStrobe,
  output logic [REG_W-1:0]   rdData
);
  ctrlStrobe_t strb;

  pmStatusCtrl i_ctrl (
    .modeCept (modeCept),
    .crcMode  (crcMode),
    .txAlignEn(txAlignEn),
    .eventIn  (eventIn),
    .rdStrobe (rdStrobe),
    .strb     (strb)
  );

  pmStatusData i_data (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdData(rdData)
  );

  a_r7_ds1_forced: assert property (@(posedge clk) disable iff (!rstN)
    !modeCept |-> rdData[6]);
  a_r8_crc_masked: assert property (@(posedge clk) disable iff (!rstN)
    !crcMode |-> (rdData[10:9] == 2'b00));
  a_r9_ebit_masked: assert property (@(posedge clk) disable iff (!rstN)
    !(modeCept && crcMode) |-> (rdData[8:7] == 2'b00));
  a_r10_txal_off: assert property (@(posedge clk) disable iff (!rstN)
    (modeCept && !txAlignEn) |-> !rdData[6]);
endmodule

// File: tb/test_pmStatusReg.sv
module test_pmStatusReg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeCept = 1'b0;
  logic        crcMode = 1'b0;
  logic        txAlignEn = 1'b0;
  logic [7:0]  eventIn = '0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  pmStatusReg i_pmStatusReg (
    .clk(clk), .rstN(rstN), .modeCept(modeCept), .crcMode(crcMode),
    .txAlignEn(txAlignEn), .eventIn(eventIn), .rdStrobe(rdStrobe), .rdData(rdData)
  );

  function automatic int posOf(input int e);
    int p [8] = '{13, 12, 10, 9, 8, 7, 6, 5};
    return p[e];
  endfunction

  function automatic bit isValid(input int e, input bit c, input bit r, input bit en);
    case (e)
      2, 3:    return r;
      4, 5:    return c && r;
      6:       return c && en;
      default: return 1'b1;
    endcase
  endfunction

  // expected word when event e is (or is not) held
  function automatic logic [15:0] expWord(input int e, input bit held, input bit c, input bit r, input bit en);
    logic [15:0] w = '0;
    if (!c) w[6] = 1'b1;
    if (held && isValid(e, c, r, en)) w[posOf(e)] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    #1;
    nRun++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s: rdData=%h expected=%h", req, rdData, exp);
    end
  endtask

  task automatic doRead(input logic [7:0] ev);
    @(negedge clk);
    rdStrobe = 1'b1;
    eventIn  = ev;
    @(negedge clk);
    rdStrobe = 1'b0;
    eventIn  = '0;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 ds1 reset", 16'h0040);
    modeCept = 1'b1;
    check("R1 cept reset", 16'h0000);

    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++)
        for (int en = 0; en < 2; en++)
          for (int e = 0; e < 8; e++)
            for (int co = 0; co < 2; co++) begin
              @(negedge clk);
              modeCept = c[0]; crcMode = r[0]; txAlignEn = en[0];
              doRead('0);
              check("R4 cleared", expWord(e, 0, c[0], r[0], en[0]));
              // fire event e alone
              eventIn = 8'(1 << e);
              @(negedge clk);
              eventIn = '0;
              check("R2/R8/R9/R10 capture", expWord(e, 1, c[0], r[0], en[0]));
              repeat (2) @(negedge clk);
              check("R3 hold", expWord(e, 1, c[0], r[0], en[0]));
              // read: data shows pre-clear value during strobe
              rdStrobe = 1'b1;
              eventIn  = co[0] ? 8'(1 << e) : 8'h00;
              check("R4 pre-clear data", expWord(e, 1, c[0], r[0], en[0]));
              @(negedge clk);
              rdStrobe = 1'b0;
              eventIn  = '0;
              if (co[0]) check("R5 coincident kept", expWord(e, 1, c[0], r[0], en[0]));
              else       check("R4 read clears", expWord(e, 0, c[0], r[0], en[0]));
              doRead('0);
              check("R4 second read clears", expWord(e, 0, c[0], r[0], en[0]));
            end

    // all events at once, every config: reserved bits, forced/masked bits
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++)
        for (int en = 0; en < 2; en++) begin
          logic [15:0] w;
          @(negedge clk);
          modeCept = c[0]; crcMode = r[0]; txAlignEn = en[0];
          doRead('0);
          eventIn = 8'hFF;
          @(negedge clk);
          eventIn = '0;
          w = c[0] ? 16'h0000 : 16'h0040;
          for (int e = 0; e < 8; e++)
            if (isValid(e, c[0], r[0], en[0])) w[posOf(e)] = 1'b1;
          check("R6 reserved zero, R7/R8/R9/R10 masks", w);
          doRead('0);
          check("R7 forced after read", c[0] ? 16'h0000 : 16'h0040);
        end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule